// File: doc/BRIEF.md
# SMBus Register-Access Slave

This block is a two-wire serial slave that lets a bus master read and write a small bank of 8-bit control registers. SCL and SDA are brought into the system clock domain through a two-flop synchronizer. Start, repeated start and stop are recognised as SDA edges while SCL is high. Bits are taken on SCL rising edges. The slave changes SDA only after SCL falls, and it drives SDA only by pulling it low through an output-enable.

After a write-direction address, the master sends a command byte. That byte picks one of two modes:

- **Single-register mode.** The master sends one data byte, or it issues a repeated start and reads one byte back.
- **Multi-register mode.** Registers are addressed from offset 0 upward. A byte count travels ahead of the data. The master supplies the count on writes, and the slave supplies it on reads.

The register contents are presented as a flat parallel vector. The drive-strength select bit of register 0 is also brought out on its own pin.

Top module: `smb_reg_slave`

## Requirements
- R1: After reset SDA is released (sda_oe_o = 0), register 0 holds 8'h40, every other register holds 8'h00, and hi_drive_o = 1.
- R2: SDA falling while SCL is high is a start (also mid-transaction, as a repeated start). SDA rising while SCL is high is a stop, which releases SDA and discards any partly received byte.
- R3: The slave acknowledges (pulls SDA low in the ninth clock) an address byte whose upper seven bits equal DEV_ADDR (default 7'h69), where bit 0 is 0 for write and 1 for read. On any other address it never drives SDA and ignores all traffic until the next start, leaving the registers unchanged.
- R4: A command byte with bits [7:5] = 3'b100 is acknowledged and selects single-register mode, with bits [4:0] as the register offset.
- R5: In single-register mode, the one data byte after the command is acknowledged and written to the selected register.
- R6: A command byte with bits [7:5] = 3'b000 is acknowledged and selects multi-register mode at offset 0. On a write, the next byte is a count N (acknowledged), and the following N data bytes are acknowledged and written to offsets 0, 1, 2, ...
- R7: In a multi-register write, data bytes beyond the count N are not acknowledged and change no register.
- R8: After a single-register command, a repeated start and a read address, the slave sends the selected register MSB first.
- R9: After a multi-register command, a repeated start and a read address, the slave first sends a count equal to NUM_REGS and then registers 0, 1, 2, ... for as long as the master acknowledges.
- R10: A not-acknowledge from the master after a sent byte ends the slave's output: SDA stays released for all later clocks until the next start or stop.
- R11: A command byte with bits [7:5] other than 3'b100 or 3'b000 is not acknowledged, and the rest of the transaction is ignored.
- R12: Register 0 bits 7, 5 and 4 always read 0 regardless of the data written. Register 0 bit 6 drives hi_drive_o (1 = high drive strength).
- R13: sda_oe_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | 8*NUM_REGS | Register bank, register k at bits [8k+7:8k] |
| hi_drive_o | output | 1 | Drive-strength select from register 0 bit 6 |

## Verification
On the SCL falling edge that closes a received data byte, the register write strobe and the decision to acknowledge fall in the same cycle. Both depend on the remaining multi-register count. The bench provokes this by sending multi-register writes with random counts followed by one extra byte. It then judges the acknowledge bit and the register vector from that same byte against a bench model. A second collision is a stop or repeated start arriving while a byte is only partly shifted in. The bench aborts after three bits and then checks that a fresh read returns untouched data.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_RX_ACK,
        S_TX,
        S_TX_ACK,
        S_IGNORE
    } smb_state_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_CMD,
        K_COUNT,
        K_DATA
    } smb_kind_e;

    localparam logic [2:0] CMD_SINGLE = 3'b100;
    localparam logic [2:0] CMD_MULTI  = 3'b000;

    localparam logic [7:0] REG0_RESET = 8'h40;
    localparam logic [7:0] REG0_WMASK = 8'h4F;

    function automatic logic [7:0] reg_reset(input int idx);
        return (idx == 0) ? REG0_RESET : 8'h00;
    endfunction

    function automatic logic [7:0] reg_wmask(input int idx);
        return (idx == 0) ? REG0_WMASK : 8'hFF;
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic scl_m;
        logic scl_s;
        logic scl_p;
        logic sda_m;
        logic sda_s;
        logic sda_p;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d       = q;
        d.scl_m = scl_i;
        d.scl_s = q.scl_m;
        d.scl_p = q.scl_s;
        d.sda_m = sda_i;
        d.sda_s = q.sda_m;
        d.sda_p = q.sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign scl_s     = q.scl_s;
    assign sda_s     = q.sda_s;
    assign scl_rise  = q.scl_s & ~q.scl_p;
    assign scl_fall  = ~q.scl_s & q.scl_p;
    assign start_det = q.scl_s & q.scl_p & q.sda_p & ~q.sda_s;
    assign stop_det  = q.scl_s & q.scl_p & ~q.sda_p & q.sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
    parameter int NUM_REGS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_i,
    input  logic [4:0]                waddr_i,
    input  logic [7:0]                wdata_i,
    output logic [NUM_REGS-1:0][7:0]  regs_o
);
    import smb_pkg::*;

    logic [NUM_REGS-1:0][7:0] regs_d, regs_q;
    logic [NUM_REGS-1:0]      hit;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
        assign hit[g] = we_i && (waddr_i == 5'(g));
    end

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit[i]) begin
                regs_d[i] = wdata_i & reg_wmask(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= reg_reset(i);
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o = regs_q;

    // R12: reserved bits of register 0 never become set
    p_rsvd_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q[0] & ~REG0_WMASK) == 8'h00);

    // R7: without a write strobe the bank keeps its contents
    p_hold_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(regs_q));

endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave #(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_REGS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_oe_o,
    output logic [8*NUM_REGS-1:0]   regs_o,
    output logic                    hi_drive_o
);
    import smb_pkg::*;

    localparam logic [7:0] NREG8 = 8'(NUM_REGS);

    typedef struct packed {
        smb_state_e st;
        smb_kind_e  kind;
        logic [2:0] cnt;
        logic [7:0] sh;
        logic       got;
        logic       oe;
        logic       go_tx;
        logic       pend;
        logic [4:0] ptr;
        logic [7:0] rem;
        logic       macked;
    } ctl_t;

    ctl_t d, q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic we;
    logic [NUM_REGS-1:0][7:0] bank;
    logic [7:0] rd_byte;
    logic [7:0] tx_byte;
    logic       tx_is_count;

    smb_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .waddr_i (q.ptr),
        .wdata_i (q.sh),
        .regs_o  (bank)
    );

    // register selected by the pointer; offsets past the bank read as zero
    always_comb begin
        rd_byte = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (q.ptr == 5'(i)) begin
                rd_byte = bank[i];
            end
        end
    end

    assign tx_is_count = q.pend;
    assign tx_byte     = tx_is_count ? NREG8 : rd_byte;

    always_comb begin
        d  = q;
        we = 1'b0;
        if (stop_det) begin
            d.st  = S_IDLE;
            d.oe  = 1'b0;
            d.got = 1'b0;
        end else if (start_det) begin
            d.st   = S_RX;
            d.kind = K_ADDR;
            d.cnt  = 3'd0;
            d.got  = 1'b0;
            d.oe   = 1'b0;
        end else begin
            unique case (q.st)
                S_RX: begin
                    if (scl_rise && !q.got) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 3'd1;
                        d.got = (q.cnt == 3'd7);
                    end else if (scl_fall && q.got) begin
                        d.got   = 1'b0;
                        d.cnt   = 3'd0;
                        d.st    = S_RX_ACK;
                        d.go_tx = 1'b0;
                        unique case (q.kind)
                            K_ADDR: begin
                                if (q.sh[7:1] == DEV_ADDR) begin
                                    d.oe    = 1'b1;
                                    d.go_tx = q.sh[0];
                                    d.kind  = K_CMD;
                                end else begin
                                    d.st = S_IGNORE;
                                end
                            end
                            K_CMD: begin
                                if (q.sh[7:5] == CMD_SINGLE) begin
                                    d.oe   = 1'b1;
                                    d.ptr  = q.sh[4:0];
                                    d.rem  = 8'd1;
                                    d.pend = 1'b0;
                                    d.kind = K_DATA;
                                end else if (q.sh[7:5] == CMD_MULTI) begin
                                    d.oe   = 1'b1;
                                    d.ptr  = 5'd0;
                                    d.rem  = 8'd0;
                                    d.pend = 1'b1;
                                    d.kind = K_COUNT;
                                end else begin
                                    d.st = S_IGNORE;
                                end
                            end
                            K_COUNT: begin
                                d.oe   = 1'b1;
                                d.rem  = q.sh;
                                d.pend = 1'b0;
                                d.kind = K_DATA;
                            end
                            K_DATA: begin
                                if (q.rem != 8'd0) begin
                                    d.oe  = 1'b1;
                                    we    = 1'b1;
                                    d.rem = q.rem - 8'd1;
                                    d.ptr = q.ptr + 5'd1;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                S_RX_ACK: begin
                    if (scl_fall) begin
                        if (q.go_tx) begin
                            d.st  = S_TX;
                            d.sh  = tx_byte;
                            d.cnt = 3'd0;
                            d.oe  = ~tx_byte[7];
                            if (tx_is_count) begin
                                d.pend = 1'b0;
                            end else begin
                                d.ptr = q.ptr + 5'd1;
                            end
                        end else begin
                            d.st = S_RX;
                            d.oe = 1'b0;
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 3'd7) begin
                            d.st = S_TX_ACK;
                            d.oe = 1'b0;
                        end else begin
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.cnt = q.cnt + 3'd1;
                            d.oe  = ~q.sh[6];
                        end
                    end
                end
                S_TX_ACK: begin
                    if (scl_rise) begin
                        d.macked = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.macked) begin
                            d.st  = S_TX;
                            d.sh  = tx_byte;
                            d.cnt = 3'd0;
                            d.oe  = ~tx_byte[7];
                            if (tx_is_count) begin
                                d.pend = 1'b0;
                            end else begin
                                d.ptr = q.ptr + 5'd1;
                            end
                        end else begin
                            d.st = S_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= S_IDLE;
            q.kind   <= K_ADDR;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o   = q.oe;
    assign regs_o     = bank;
    assign hi_drive_o = bank[0][6];

    // R13: the slave only moves SDA while the synchronized clock is low
    p_sda_move_scl_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe != $past(q.oe)) |-> !scl_s);

    // R3: an ignored transaction never drives the line
    p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IGNORE) |-> !q.oe);

    // R2: a stop returns to idle with SDA released
    p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (q.st == S_IDLE && !q.oe));

    // R10: silence lasts until a start or stop arrives
    p_ignore_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IGNORE && !start_det && !stop_det) |=> (q.st == S_IGNORE));

    // R5: every register write is acknowledged in the following clock
    p_write_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> q.oe);

endmodule

// File: tb/smb_reg_slave_bench.sv
module smb_reg_slave_bench;

    localparam logic [6:0] ADDR = 7'h69;
    localparam int NREG = 8;
    localparam int Q    = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic scl;
    logic m_sda;
    logic sda_bus;
    logic sda_oe;
    logic hi_drive;
    logic [8*NREG-1:0] regs;

    int tests = 0;
    int fails = 0;
    int viol  = 0;
    logic oe_prev = 1'b0;
    logic [7:0] mdl [NREG];

    always #5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    smb_reg_slave #(.DEV_ADDR(ADDR), .NUM_REGS(NREG)) u_smb_reg_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .sda_oe_o   (sda_oe),
        .regs_o     (regs),
        .hi_drive_o (hi_drive)
    );

    // R13 monitor: SDA drive must not move while SCL is high
    always @(negedge clk) begin
        if (rst_n === 1'b1 && sda_oe !== oe_prev && scl === 1'b1) viol++;
        oe_prev = sda_oe;
    end

    function automatic logic [7:0] masked(input int idx, input logic [7:0] v);
        return (idx == 0) ? (v & 8'h4F) : v;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic bitx(input logic b, output logic s);
        m_sda = b;
        tick(Q);
        scl = 1'b1;
        tick(Q);
        s = sda_bus;
        tick(Q);
        scl = 1'b0;
        tick(Q);
    endtask

    task automatic bus_start();
        m_sda = 1'b1;
        tick(Q);
        scl = 1'b1;
        tick(Q);
        m_sda = 1'b0;
        tick(Q);
        scl = 1'b0;
        tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0;
        tick(Q);
        scl = 1'b1;
        tick(Q);
        m_sda = 1'b1;
        tick(2 * Q);
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bitx(b[i], s);
        bitx(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv(input logic mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bitx(1'b1, s);
            b[i] = s;
        end
        bitx(~mack, s);
    endtask

    task automatic cmp_regs(input string req);
        for (int i = 0; i < NREG; i++) check(req, 32'(regs[i*8 +: 8]), 32'(mdl[i]));
    endtask

    task automatic wr_single(input int off, input logic [7:0] v);
        logic a;
        bus_start();
        send({ADDR, 1'b0}, a); check("R3 addr ack", 32'(a), 1);
        send({3'b100, 5'(off)}, a); check("R4 cmd ack", 32'(a), 1);
        send(v, a); check("R5 data ack", 32'(a), 1);
        bus_stop();
        mdl[off] = masked(off, v);
        tick(4);
    endtask

    task automatic rd_single(input int off, output logic [7:0] v);
        logic a;
        bus_start();
        send({ADDR, 1'b0}, a); check("R3 addr ack", 32'(a), 1);
        send({3'b100, 5'(off)}, a); check("R4 cmd ack", 32'(a), 1);
        bus_start();
        send({ADDR, 1'b1}, a); check("R8 read addr ack", 32'(a), 1);
        recv(1'b0, v);
        bus_stop();
        tick(4);
    endtask

    task automatic wr_multi(input int n);
        logic a;
        logic [7:0] v;
        bus_start();
        send({ADDR, 1'b0}, a); check("R3 addr ack", 32'(a), 1);
        send(8'h00, a); check("R6 cmd ack", 32'(a), 1);
        send(8'(n), a); check("R6 count ack", 32'(a), 1);
        for (int k = 0; k < n; k++) begin
            v = 8'($urandom);
            send(v, a); check("R6 data ack", 32'(a), 1);
            mdl[k] = masked(k, v);
        end
        send(8'($urandom), a); check("R7 extra byte nack", 32'(a), 0);
        bus_stop();
        tick(4);
        cmp_regs("R7 R6 bank");
    endtask

    task automatic rd_multi();
        logic a;
        logic [7:0] v;
        bus_start();
        send({ADDR, 1'b0}, a);
        send(8'h00, a); check("R6 cmd ack", 32'(a), 1);
        bus_start();
        send({ADDR, 1'b1}, a); check("R9 addr ack", 32'(a), 1);
        recv(1'b1, v); check("R9 count", 32'(v), NREG);
        for (int k = 0; k < NREG; k++) begin
            recv(k != NREG - 1, v);
            check("R9 data", 32'(v), 32'(mdl[k]));
        end
        bus_stop();
        tick(4);
    endtask

    initial begin
        logic a;
        logic s;
        logic [7:0] v;
        int off;
        void'($urandom(32'h5eed_0042));
        scl = 1'b1;
        m_sda = 1'b1;
        rst_n = 1'b0;
        for (int i = 0; i < NREG; i++) mdl[i] = (i == 0) ? 8'h40 : 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        check("R1 oe", 32'(sda_oe), 0);
        check("R1 hi_drive", 32'(hi_drive), 1);
        cmp_regs("R1 reset bank");

        // R12 reserved bits and drive select
        wr_single(0, 8'hFF);
        check("R12 reg0 masked", 32'(regs[7:0]), 32'h4F);
        check("R12 hi_drive", 32'(hi_drive), 1);
        wr_single(0, 8'h00);
        check("R12 hi_drive low", 32'(hi_drive), 0);

        for (int t = 0; t < 10; t++) begin
            off = int'($urandom % NREG);
            wr_single(off, 8'($urandom));
        end
        cmp_regs("R5 bank");

        for (int t = 0; t < 6; t++) begin
            off = int'($urandom % NREG);
            rd_single(off, v);
            check("R8 read data", 32'(v), 32'(mdl[off]));
        end

        wr_multi(3);
        wr_multi(NREG);
        rd_multi();

        // R10: master NACK silences the slave
        bus_start();
        send({ADDR, 1'b0}, a);
        send(8'h00, a);
        bus_start();
        send({ADDR, 1'b1}, a);
        recv(1'b1, v); check("R10 count", 32'(v), NREG);
        recv(1'b0, v); check("R10 first data", 32'(v), 32'(mdl[0]));
        recv(1'b0, v); check("R10 silent after nack", 32'(v), 32'hFF);
        bus_stop();
        tick(4);

        // R3: foreign address
        bus_start();
        send({ADDR ^ 7'h01, 1'b0}, a); check("R3 mismatch nack", 32'(a), 0);
        send(8'h81, a); check("R3 ignored cmd", 32'(a), 0);
        send(8'hA5, a); check("R3 ignored data", 32'(a), 0);
        bus_stop();
        tick(4);
        cmp_regs("R3 bank");

        // R11: unsupported command code
        bus_start();
        send({ADDR, 1'b0}, a); check("R11 addr ack", 32'(a), 1);
        send(8'h21, a); check("R11 cmd nack", 32'(a), 0);
        send(8'h5A, a); check("R11 data ignored", 32'(a), 0);
        bus_stop();
        tick(4);
        cmp_regs("R11 bank");

        // R2: stop in the middle of a data byte
        off = 1;
        bus_start();
        send({ADDR, 1'b0}, a);
        send({3'b100, 5'(off)}, a);
        bitx(1'b1, s);
        bitx(1'b0, s);
        bitx(1'b1, s);
        bus_stop();
        tick(4);
        check("R2 oe after stop", 32'(sda_oe), 0);
        cmp_regs("R2 bank after abort");
        rd_single(off, v);
        check("R2 read after abort", 32'(v), 32'(mdl[off]));

        check("R13 sda moved with scl high", 32'(viol), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule